// File: doc/BRIEF.md
# Logic Capture Control and Status Registers

This block is the register slave of a 16-channel logic capture engine. A host-side controller reaches it over a simple synchronous bus. The bus has a 16-bit address, a write strobe, a read strobe, 32-bit write data and 32-bit registered read data. The block holds the settings the capture datapath needs: the channel enable mask, the capture duration, the memory read pointer, the memory control flags, the capture count, the trigger setup and the sample-rate divider. It also reports the live capture flags, the memory write pointer, memory data, the captured total and a fixed identification word.

Two addresses serve two purposes. At the identification address, a read returns a constant and a write loads the trigger edge and match values. At the captured-total address, a read returns the total from the datapath and a write loads the divider. A divider of N gives one sample-enable pulse every N+1 clocks. With a 100 MHz base clock, N is the base rate divided by the wanted rate, minus one.

The capture control word does two jobs. On a write it sets three control flags, and when its trigger-enable bit is set it also carries a 16-bit trigger channel mask in its upper half. On a read it returns a 7-bit status word that mixes those flags with four flags driven by the datapath.

Top module: `capture_csr`

## Requirements
- R1: After reset, every stored setting is zero, except the capture count. The capture count resets to the memory depth minus 5, which is 0x0003FFFB for a depth of 262144. Read data resets to zero.
- R2: A read of 0x10B4 returns 0x12345678. A write to 0x10B4 puts bits 31:16 on the trigger edge mask output and bits 15:0 on the trigger match value output. After such a write, a read of 0x10B4 still returns 0x12345678.
- R3: A read of 0x10BC returns the captured-total input. A write to 0x10BC loads the divider and leaves that readback unchanged.
- R4: The registers at 0x1000 (channel mask, 16 bits, read back zero-extended), 0x1010 (duration), 0x1074 (memory read pointer) and 0x10B0 (capture count) read back what was written and drive their outputs.
- R5: In memory control at 0x107C, bit 0 drives the pointer-reset output and bit 1 drives the memory write-enable output. A read returns these two bits with all other bits zero.
- R6: A write to capture control at 0x10B8 stores bit 2 (trigger enable), bit 3 (clear timebase) and bit 5 (sample enable). A read returns only 7 status bits: bit 0 fifo32-full input, bit 1 fifo64-full input, bit 2 trigger enable, bit 3 clear timebase, bit 4 fifo-empty input, bit 5 sample enable, bit 6 counter-running input.
- R7: A capture control write loads the trigger channel mask from bits 31:16 only when bit 2 of the written word is set. Otherwise the mask keeps its value.
- R8: 0x1070 reads the write-pointer input and 0x1078 reads the memory-data input. Writes to these two addresses change nothing.
- R9: A read of an unmapped address returns zero. A write to an unmapped address changes no output.
- R10: Read data changes on the clock edge that samples the read strobe and holds its value on every clock without a read strobe.
- R11: With divider value N, the sample strobe is high for one clock in every N+1 clocks. With N = 0 it is high on every clock.
- R12: A write to the divider restarts the count. The strobe is low for the N clocks after the write edge and high in the clock after that.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 16 | Register address |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid one clock after busRd |
| fifo32Full | input | 1 | Status flag from the datapath |
| fifo64Full | input | 1 | Status flag from the datapath |
| fifoEmpty | input | 1 | Status flag from the datapath |
| countRunning | input | 1 | Capture counter has not yet ended |
| wrPtrIn | input | 32 | Capture memory write pointer |
| memDataIn | input | 32 | Capture memory data word |
| capTotalIn | input | 32 | Captured sample total |
| chanMask | output | 16 | Enabled channels |
| duration | output | 32 | Capture duration setting |
| memRdPtr | output | 32 | Capture memory read pointer |
| memPtrReset | output | 1 | Reset of the memory pointers |
| memWriteEn | output | 1 | Enable for writes into capture memory |
| capCount | output | 32 | Capture count setting |
| trigEdgeMask | output | 16 | Channels that trigger on an edge |
| trigValues | output | 16 | Trigger match values |
| trigChanMask | output | 16 | Channels that take part in the trigger |
| trigEnable | output | 1 | Trigger enable |
| clrTimebase | output | 1 | Clear the timebase |
| sampleEnable | output | 1 | Sample enable |
| sampleStrobe | output | 1 | One-clock sample-enable pulse from the divider |

## Verification
Each aliased address is written and then read, to show that its read side and write side are separate registers. The capture control word is written once with bit 2 set and once with bit 2 clear, with different upper halves. This shows whether the mask load depends on bit 2. The status readback is taken under two opposite settings of the four flag inputs, which separates the input flags from the stored flags. The divider is run at 0 and at 3, and it is rewritten partway through a period. These cases tell a correct period apart from an off-by-one, and a restart apart from a free-running counter.

// File: rtl/capture_csr_pkg.sv
package capture_csr_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 16;

  localparam logic [ADDR_W-1:0] A_CHAN   = 16'h1000;
  localparam logic [ADDR_W-1:0] A_DUR    = 16'h1010;
  localparam logic [ADDR_W-1:0] A_WRPTR  = 16'h1070;
  localparam logic [ADDR_W-1:0] A_RDPTR  = 16'h1074;
  localparam logic [ADDR_W-1:0] A_MDATA  = 16'h1078;
  localparam logic [ADDR_W-1:0] A_MCTRL  = 16'h107C;
  localparam logic [ADDR_W-1:0] A_CCOUNT = 16'h10B0;
  localparam logic [ADDR_W-1:0] A_IDTRG  = 16'h10B4;
  localparam logic [ADDR_W-1:0] A_CCTRL  = 16'h10B8;
  localparam logic [ADDR_W-1:0] A_TOTDIV = 16'h10BC;

  localparam logic [DATA_W-1:0] ID_WORD = 32'h12345678;

  typedef enum logic [3:0] {
    RS_ZERO, RS_CHAN, RS_DUR, RS_WRPTR, RS_RDPTR, RS_MDATA,
    RS_MCTRL, RS_CCOUNT, RS_ID, RS_STATUS, RS_TOTAL
  } rdSel_e;

  typedef struct packed {
    logic   wrChan;
    logic   wrDur;
    logic   wrRdPtr;
    logic   wrMemCtrl;
    logic   wrCapCount;
    logic   wrTrig;
    logic   wrCapCtrl;
    logic   wrDiv;
    logic   rdEn;
    rdSel_e rdSel;
  } csrStrobes_t;
endpackage

// File: rtl/csr_decode.sv
module csr_decode
  import capture_csr_pkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  output csrStrobes_t       strb
);
  always_comb begin
    strb = '0;
    strb.rdSel = RS_ZERO;
    strb.rdEn  = busRd;
    if (busWr) begin
      unique case (busAddr)
        A_CHAN:   strb.wrChan     = 1'b1;
        A_DUR:    strb.wrDur      = 1'b1;
        A_RDPTR:  strb.wrRdPtr    = 1'b1;
        A_MCTRL:  strb.wrMemCtrl  = 1'b1;
        A_CCOUNT: strb.wrCapCount = 1'b1;
        A_IDTRG:  strb.wrTrig     = 1'b1;
        A_CCTRL:  strb.wrCapCtrl  = 1'b1;
        A_TOTDIV: strb.wrDiv      = 1'b1;
        default:  ;
      endcase
    end
    unique case (busAddr)
      A_CHAN:   strb.rdSel = RS_CHAN;
      A_DUR:    strb.rdSel = RS_DUR;
      A_WRPTR:  strb.rdSel = RS_WRPTR;
      A_RDPTR:  strb.rdSel = RS_RDPTR;
      A_MDATA:  strb.rdSel = RS_MDATA;
      A_MCTRL:  strb.rdSel = RS_MCTRL;
      A_CCOUNT: strb.rdSel = RS_CCOUNT;
      A_IDTRG:  strb.rdSel = RS_ID;
      A_CCTRL:  strb.rdSel = RS_STATUS;
      A_TOTDIV: strb.rdSel = RS_TOTAL;
      default:  strb.rdSel = RS_ZERO;
    endcase
  end
endmodule

// File: rtl/csr_datapath.sv
module csr_datapath
  import capture_csr_pkg::*;
#(
  parameter int CHAN_N    = 16,
  parameter int MEM_DEPTH = 262144,
  parameter int DIV_W     = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  csrStrobes_t       strb,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              fifo32Full,
  input  logic              fifo64Full,
  input  logic              fifoEmpty,
  input  logic              countRunning,
  input  logic [DATA_W-1:0] wrPtrIn,
  input  logic [DATA_W-1:0] memDataIn,
  input  logic [DATA_W-1:0] capTotalIn,
  output logic [CHAN_N-1:0] chanMask,
  output logic [DATA_W-1:0] duration,
  output logic [DATA_W-1:0] memRdPtr,
  output logic              memPtrReset,
  output logic              memWriteEn,
  output logic [DATA_W-1:0] capCount,
  output logic [CHAN_N-1:0] trigEdgeMask,
  output logic [CHAN_N-1:0] trigValues,
  output logic [CHAN_N-1:0] trigChanMask,
  output logic              trigEnable,
  output logic              clrTimebase,
  output logic              sampleEnable,
  output logic              sampleStrobe
);
  localparam logic [DATA_W-1:0] CCOUNT_RST = DATA_W'(MEM_DEPTH - 5);
  localparam int HI = DATA_W / 2;

  logic [DIV_W-1:0]  divCount;
  logic [DIV_W-1:0]  divCnt;
  logic [DATA_W-1:0] rdMux;
  logic [6:0]        statusWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chanMask     <= '0;
      duration     <= '0;
      memRdPtr     <= '0;
      memPtrReset  <= 1'b0;
      memWriteEn   <= 1'b0;
      capCount     <= CCOUNT_RST;
      trigEdgeMask <= '0;
      trigValues   <= '0;
      trigChanMask <= '0;
      trigEnable   <= 1'b0;
      clrTimebase  <= 1'b0;
      sampleEnable <= 1'b0;
    end else begin
      if (strb.wrChan)     chanMask <= busWdata[CHAN_N-1:0];
      if (strb.wrDur)      duration <= busWdata;
      if (strb.wrRdPtr)    memRdPtr <= busWdata;
      if (strb.wrCapCount) capCount <= busWdata;
      if (strb.wrMemCtrl) begin
        memPtrReset <= busWdata[0];
        memWriteEn  <= busWdata[1];
      end
      if (strb.wrTrig) begin
        trigEdgeMask <= busWdata[HI +: CHAN_N];
        trigValues   <= busWdata[CHAN_N-1:0];
      end
      if (strb.wrCapCtrl) begin
        trigEnable   <= busWdata[2];
        clrTimebase  <= busWdata[3];
        sampleEnable <= busWdata[5];
        if (busWdata[2]) trigChanMask <= busWdata[HI +: CHAN_N];
      end
    end
  end

  // Sample-rate divider: counts 0..divCount, pulses at the top.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCount <= '0;
      divCnt   <= '0;
    end else if (strb.wrDiv) begin
      divCount <= busWdata[DIV_W-1:0];
      divCnt   <= '0;
    end else if (divCnt >= divCount) begin
      divCnt <= '0;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  assign sampleStrobe = (divCnt == divCount);

  assign statusWord = {countRunning, sampleEnable, fifoEmpty, clrTimebase,
                       trigEnable, fifo64Full, fifo32Full};

  always_comb begin
    unique case (strb.rdSel)
      RS_CHAN:   rdMux = DATA_W'(chanMask);
      RS_DUR:    rdMux = duration;
      RS_WRPTR:  rdMux = wrPtrIn;
      RS_RDPTR:  rdMux = memRdPtr;
      RS_MDATA:  rdMux = memDataIn;
      RS_MCTRL:  rdMux = {{(DATA_W-2){1'b0}}, memWriteEn, memPtrReset};
      RS_CCOUNT: rdMux = capCount;
      RS_ID:     rdMux = ID_WORD;
      RS_STATUS: rdMux = DATA_W'(statusWord);
      RS_TOTAL:  rdMux = capTotalIn;
      default:   rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)          busRdata <= '0;
    else if (strb.rdEn) busRdata <= rdMux;
  end
endmodule

// File: rtl/capture_csr.sv
module capture_csr
  import capture_csr_pkg::*;
#(
  parameter int CHAN_N    = 16,
  parameter int MEM_DEPTH = 262144,
  parameter int DIV_W     = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [15:0]       busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic              fifo32Full,
  input  logic              fifo64Full,
  input  logic              fifoEmpty,
  input  logic              countRunning,
  input  logic [31:0]       wrPtrIn,
  input  logic [31:0]       memDataIn,
  input  logic [31:0]       capTotalIn,
  output logic [CHAN_N-1:0] chanMask,
  output logic [31:0]       duration,
  output logic [31:0]       memRdPtr,
  output logic              memPtrReset,
  output logic              memWriteEn,
  output logic [31:0]       capCount,
  output logic [CHAN_N-1:0] trigEdgeMask,
  output logic [CHAN_N-1:0] trigValues,
  output logic [CHAN_N-1:0] trigChanMask,
  output logic              trigEnable,
  output logic              clrTimebase,
  output logic              sampleEnable,
  output logic              sampleStrobe
);
  csrStrobes_t strb;

  csr_decode i_decode (
    .busAddr(busAddr), .busWr(busWr), .busRd(busRd), .strb(strb)
  );

  csr_datapath #(.CHAN_N(CHAN_N), .MEM_DEPTH(MEM_DEPTH), .DIV_W(DIV_W)) i_datapath (
    .clk(clk), .rstN(rstN), .strb(strb), .busWdata(busWdata),
    .busRdata(busRdata), .fifo32Full(fifo32Full), .fifo64Full(fifo64Full),
    .fifoEmpty(fifoEmpty), .countRunning(countRunning), .wrPtrIn(wrPtrIn),
    .memDataIn(memDataIn), .capTotalIn(capTotalIn), .chanMask(chanMask),
    .duration(duration), .memRdPtr(memRdPtr), .memPtrReset(memPtrReset),
    .memWriteEn(memWriteEn), .capCount(capCount), .trigEdgeMask(trigEdgeMask),
    .trigValues(trigValues), .trigChanMask(trigChanMask),
    .trigEnable(trigEnable), .clrTimebase(clrTimebase),
    .sampleEnable(sampleEnable), .sampleStrobe(sampleStrobe)
  );
endmodule

// File: rtl/capture_csr_chk.sv
module capture_csr_chk (
  input logic        clk,
  input logic        rstN,
  input logic [15:0] busAddr,
  input logic        busWr,
  input logic        busRd,
  input logic [31:0] busWdata,
  input logic [31:0] busRdata,
  input logic [15:0] trigChanMask,
  input logic        memPtrReset,
  input logic        memWriteEn,
  input logic        sampleStrobe
);
  // R2
  id_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr == 16'h10B4) |=> (busRdata == 32'h12345678));

  // R9
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr[1:0] != 2'b00) |=> (busRdata == 32'h0));

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busRd |=> $stable(busRdata));

  // R7
  trig_mask_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == 16'h10B8 && !busWdata[2]) |=> $stable(trigChanMask));

  // R5
  mem_ctrl_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == 16'h107C) |=>
      (memPtrReset == $past(busWdata[0]) && memWriteEn == $past(busWdata[1])));

  // R12
  div_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == 16'h10BC && busWdata != 32'h0) |=> !sampleStrobe);
endmodule

bind capture_csr capture_csr_chk u_capture_csr_chk (.*);

// File: tb/test_capture_csr.sv
`timescale 1ns/1ps
module test_capture_csr;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] busAddr = '0;
  logic        busWr = 1'b0, busRd = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        fifo32Full = 1'b0, fifo64Full = 1'b0, fifoEmpty = 1'b0, countRunning = 1'b0;
  logic [31:0] wrPtrIn = 32'h0000_1234, memDataIn = 32'hCAFE_F00D, capTotalIn = 32'h0002_0000;
  logic [15:0] chanMask, trigEdgeMask, trigValues, trigChanMask;
  logic [31:0] duration, memRdPtr, capCount;
  logic        memPtrReset, memWriteEn, trigEnable, clrTimebase, sampleEnable, sampleStrobe;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  capture_csr i_capture_csr (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    @(negedge clk);
    busRd = 1'b0;
    d = busRdata;
  endtask

  task automatic testReset();
    check("R1 capCount", capCount, 32'h0003FFFB);
    check("R1 chanMask", {16'h0, chanMask}, 32'h0);
    check("R1 duration", duration, 32'h0);
    check("R1 trigChanMask", {16'h0, trigChanMask}, 32'h0);
    check("R1 flags", {29'h0, trigEnable, sampleEnable, memWriteEn}, 32'h0);
    check("R1 busRdata", busRdata, 32'h0);
  endtask

  task automatic testIdAlias();
    logic [31:0] d;
    busRead(16'h10B4, d);
    check("R2 id read", d, 32'h12345678);
    busWrite(16'h10B4, 32'hA5A5_3C3C);
    check("R2 edge mask", {16'h0, trigEdgeMask}, 32'h0000A5A5);
    check("R2 match values", {16'h0, trigValues}, 32'h00003C3C);
    busRead(16'h10B4, d);
    check("R2 id after write", d, 32'h12345678);
  endtask

  task automatic testTotalAlias();
    logic [31:0] d;
    busWrite(16'h10BC, 32'd9);
    busRead(16'h10BC, d);
    check("R3 total read", d, 32'h0002_0000);
    busWrite(16'h10BC, 32'd0);
  endtask

  task automatic testRwRegs();
    logic [31:0] d;
    busWrite(16'h1000, 32'hFFFF_BEEF);
    busRead(16'h1000, d);
    check("R4 chan mask", d, 32'h0000BEEF);
    check("R4 chan out", {16'h0, chanMask}, 32'h0000BEEF);
    busWrite(16'h1010, 32'h0000_03E8);
    busRead(16'h1010, d);
    check("R4 duration", d, 32'h0000_03E8);
    busWrite(16'h1074, 32'h0000_0002);
    busRead(16'h1074, d);
    check("R4 rd ptr", d, 32'h2);
    busWrite(16'h10B0, 32'h0001_0000);
    busRead(16'h10B0, d);
    check("R4 cap count", d, 32'h0001_0000);
  endtask

  task automatic testMemCtrl();
    logic [31:0] d;
    busWrite(16'h107C, 32'hFFFF_FFFD);
    check("R5 reset bit", {31'h0, memPtrReset}, 32'h1);
    check("R5 write bit", {31'h0, memWriteEn}, 32'h0);
    busRead(16'h107C, d);
    check("R5 readback", d, 32'h1);
    busWrite(16'h107C, 32'h2);
    busRead(16'h107C, d);
    check("R5 readback write-en", d, 32'h2);
  endtask

  task automatic testCapCtrl();
    logic [31:0] d;
    busWrite(16'h10B8, 32'h1234_FFFF);
    check("R6 stored flags", {29'h0, trigEnable, clrTimebase, sampleEnable}, 32'h7);
    check("R7 mask loaded", {16'h0, trigChanMask}, 32'h00001234);
    fifo32Full = 1'b0; fifo64Full = 1'b1; fifoEmpty = 1'b0; countRunning = 1'b1;
    busRead(16'h10B8, d);
    check("R6 status a", d, 32'h0000006E);
    busWrite(16'h10B8, 32'h9999_0008);
    check("R7 mask kept", {16'h0, trigChanMask}, 32'h00001234);
    fifo32Full = 1'b1; fifo64Full = 1'b0; fifoEmpty = 1'b1; countRunning = 1'b0;
    busRead(16'h10B8, d);
    check("R6 status b", d, 32'h00000019);
  endtask

  task automatic testReadOnly();
    logic [31:0] d;
    busWrite(16'h1070, 32'hFFFF_FFFF);
    busWrite(16'h1078, 32'hFFFF_FFFF);
    busRead(16'h1070, d);
    check("R8 wr ptr", d, 32'h0000_1234);
    busRead(16'h1078, d);
    check("R8 mem data", d, 32'hCAFE_F00D);
    check("R8 no side effect", duration, 32'h0000_03E8);
  endtask

  task automatic testUnmapped();
    logic [31:0] d;
    busWrite(16'h1004, 32'hFFFF_FFFF);
    busWrite(16'h2000, 32'hFFFF_FFFF);
    check("R9 chan kept", {16'h0, chanMask}, 32'h0000BEEF);
    check("R9 dur kept", duration, 32'h0000_03E8);
    check("R9 ptr kept", memRdPtr, 32'h2);
    check("R9 count kept", capCount, 32'h0001_0000);
    busRead(16'h1004, d);
    check("R9 unmapped read", d, 32'h0);
  endtask

  task automatic testLatency();
    logic [31:0] d;
    busRead(16'h1000, d);
    @(negedge clk);
    busAddr = 16'h10B4; busRd = 1'b1;
    #1 check("R10 before edge", busRdata, 32'h0000BEEF);
    @(negedge clk);
    busRd = 1'b0;
    check("R10 after edge", busRdata, 32'h12345678);
    busAddr = 16'h1000;
    @(negedge clk);
    check("R10 hold", busRdata, 32'h12345678);
  endtask

  task automatic testDivider();
    busWrite(16'h10BC, 32'd0);
    for (int k = 0; k < 4; k++) begin
      check("R11 div0 every clock", {31'h0, sampleStrobe}, 32'h1);
      @(negedge clk);
    end
    busWrite(16'h10BC, 32'd3);
    for (int k = 0; k < 8; k++) begin
      check("R11 div3 period", {31'h0, sampleStrobe}, (k % 4 == 3) ? 32'h1 : 32'h0);
      @(negedge clk);
    end
  endtask

  task automatic testRestart();
    busWrite(16'h10BC, 32'd3);
    @(negedge clk);
    @(negedge clk);
    busWrite(16'h10BC, 32'd3);
    for (int k = 0; k < 4; k++) begin
      check("R12 restart", {31'h0, sampleStrobe}, (k == 3) ? 32'h1 : 32'h0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    check("R11 div0 after reset", {31'h0, sampleStrobe}, 32'h1);
    testIdAlias();
    testTotalAlias();
    testRwRegs();
    testMemCtrl();
    testCapCtrl();
    testReadOnly();
    testUnmapped();
    testLatency();
    testDivider();
    testRestart();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule